// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This unit compares two IEEE 754 operands and turns the outcome into a 4-bit condition code. The operands can be half, single or double precision. The code is ordered N, Z, C, V from the most significant bit down. Both operand buses are 64 bits wide. A narrower value sits in the low bits, and the unused upper bits are ignored.

A compare-with-zero control replaces the second operand with positive zero of the selected format. A per-operation trap-mode bit chooses when the unit raises invalid operation:
- When the bit is 1, any NaN operand raises it.
- When the bit is 0, only a signalling NaN raises it.

Invalid operation is recorded in a sticky flag. Only an explicit clear input resets that flag.

Every compare takes exactly one cycle, whatever the operand values or the previous flags. The flags also appear in bits 31:28 of a 32-bit status word that the surrounding logic can merge into its own status register.

Top module: `fp_cmp_flags`

## Requirements
- R1: Format code `fmt_i` selects the operand format: 2'b01 is half (5-bit exponent, 10-bit fraction), 2'b10 is single (8/23) and 2'b11 is double (11/52). Operand bits above the selected width have no effect on any output.
- R2: When `valid_i` is high with `fmt_i` = 2'b00, `bad_fmt_o` is high in the next cycle and `nzcv_o` and `inv_sticky_o` keep their values. `bad_fmt_o` is low in every other cycle.
- R3: An ordered compare gives these codes:
  - Operand A below B: `nzcv_o` = 4'b1000.
  - A equal to B: 4'b0110.
  - A above B: 4'b0010.
  - Positive and negative zero compare equal, and infinities order by sign.
- R4: If either operand is a NaN, the compare is unordered and `nzcv_o` = 4'b0011.
- R5: With `zero_cmp_i` high, operand B is replaced by positive zero of the selected format, and `op_b_i` is ignored.
- R6: With `nan_trap_all_i` high, a quiet or signalling NaN in either operand sets `inv_sticky_o`.
- R7: With `nan_trap_all_i` low, only a signalling NaN sets `inv_sticky_o`. A signalling NaN has an all-ones exponent, a nonzero fraction and the top fraction bit clear. A quiet NaN leaves the flag unchanged.
- R8: `inv_sticky_o` stays high until `clr_inv_i` is pulsed. A clear and a new set in the same cycle leave the flag set.
- R9: `status_o[31:28]` equals `nzcv_o`, and `status_o[27:0]` is zero.
- R10: `nzcv_o` updates exactly one clock edge after a legal `valid_i` and holds its value in cycles with no valid strobe.
- R11: After reset, `nzcv_o` = 4'b0000 and `inv_sticky_o` and `bad_fmt_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Compare strobe |
| fmt_i | input | 2 | Operand format code |
| zero_cmp_i | input | 1 | Compare operand A against positive zero |
| nan_trap_all_i | input | 1 | 1: any NaN raises invalid; 0: only signalling NaN |
| op_a_i | input | 64 | Operand A, right-aligned |
| op_b_i | input | 64 | Operand B, right-aligned |
| clr_inv_i | input | 1 | Clear the sticky invalid flag |
| nzcv_o | output | 4 | Registered N, Z, C, V flags |
| status_o | output | 32 | Flags placed at bits 31:28 |
| inv_sticky_o | output | 1 | Sticky invalid-operation flag |
| bad_fmt_o | output | 1 | Illegal format seen in the previous cycle |

## Verification
The assertions watch several behaviours on every cycle:
- the illegal-format pulse and the flag hold it requires;
- the flags holding between strobes;
- the set of legal flag codes;
- the status word layout;
- sticky retention and clearing;
- equality of identical single-precision operands, zero compares and double-precision NaN trapping.

Only the bench's scenarios can show that the ordering is right across all three formats and that upper bits are ignored. The same holds for the signalling/quiet distinction when trapping only on signalling NaNs, and for the signed-zero and infinity corners. Those are checked against a reference function over random and directed operands.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int OP_W   = 64;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int H_E = 5;
  localparam int H_F = 10;
  localparam int S_E = 8;
  localparam int S_F = 23;
  localparam int D_E = EXP_W;
  localparam int D_F = FRAC_W;
  localparam int NUM_OPS = 2;

  typedef enum logic [1:0] {
    FMT_BAD  = 2'b00,
    FMT_HALF = 2'b01,
    FMT_SGL  = 2'b10,
    FMT_DBL  = 2'b11
  } fmt_e;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;   // left-justified
    logic              is_zero;
    logic              is_nan;
    logic              is_snan;
  } fp_fields_t;

  localparam logic [3:0] NZCV_LT = 4'b1000;
  localparam logic [3:0] NZCV_EQ = 4'b0110;
  localparam logic [3:0] NZCV_GT = 4'b0010;
  localparam logic [3:0] NZCV_UN = 4'b0011;
endpackage

// File: rtl/fpc_unpack.sv
module fpc_unpack
  import fpc_pkg::*;
(
  input  fmt_e            fmt_i,
  input  logic            force_zero_i,
  input  logic [OP_W-1:0] op_i,
  output fp_fields_t      fld_o
);
  logic              sign;
  logic [EXP_W-1:0]  exp;
  logic [FRAC_W-1:0] frac;
  logic              exp_ones;

  always_comb begin
    sign = 1'b0;
    exp = '0;
    frac = '0;
    exp_ones = 1'b0;
    unique case (fmt_i)
      FMT_HALF: begin
        sign = op_i[H_E+H_F];
        exp = EXP_W'(op_i[H_E+H_F-1 -: H_E]);
        frac = {op_i[H_F-1:0], {(FRAC_W-H_F){1'b0}}};
        exp_ones = &op_i[H_E+H_F-1 -: H_E];
      end
      FMT_SGL: begin
        sign = op_i[S_E+S_F];
        exp = EXP_W'(op_i[S_E+S_F-1 -: S_E]);
        frac = {op_i[S_F-1:0], {(FRAC_W-S_F){1'b0}}};
        exp_ones = &op_i[S_E+S_F-1 -: S_E];
      end
      FMT_DBL: begin
        sign = op_i[D_E+D_F];
        exp = op_i[D_E+D_F-1 -: D_E];
        frac = op_i[D_F-1:0];
        exp_ones = &op_i[D_E+D_F-1 -: D_E];
      end
      default: ;
    endcase
    if (force_zero_i) begin
      sign = 1'b0;
      exp = '0;
      frac = '0;
      exp_ones = 1'b0;
    end
  end

  always_comb begin
    fld_o.sign    = sign;
    fld_o.exp     = exp;
    fld_o.frac    = frac;
    fld_o.is_zero = (exp == '0) && (frac == '0);
    fld_o.is_nan  = exp_ones && (frac != '0);
    fld_o.is_snan = exp_ones && (frac != '0) && !frac[FRAC_W-1];
  end
endmodule

// File: rtl/fpc_order.sv
module fpc_order
  import fpc_pkg::*;
(
  input  fp_fields_t a_i,
  input  fp_fields_t b_i,
  input  logic       nan_trap_all_i,
  output logic [3:0] nzcv_o,
  output logic       inv_o
);
  logic [EXP_W+FRAC_W-1:0] mag_a, mag_b;
  logic mag_lt, mag_eq;

  assign mag_a  = {a_i.exp, a_i.frac};
  assign mag_b  = {b_i.exp, b_i.frac};
  assign mag_lt = mag_a < mag_b;
  assign mag_eq = mag_a == mag_b;

  always_comb begin
    if (a_i.is_nan || b_i.is_nan)       nzcv_o = NZCV_UN;
    else if (a_i.is_zero && b_i.is_zero) nzcv_o = NZCV_EQ;
    else if (a_i.sign != b_i.sign)      nzcv_o = a_i.sign ? NZCV_LT : NZCV_GT;
    else if (mag_eq)                    nzcv_o = NZCV_EQ;
    else if (mag_lt ^ a_i.sign)         nzcv_o = NZCV_LT;
    else                                nzcv_o = NZCV_GT;
  end

  assign inv_o = nan_trap_all_i ? (a_i.is_nan | b_i.is_nan)
                                : (a_i.is_snan | b_i.is_snan);
endmodule

// File: rtl/fp_cmp_flags.sv
module fp_cmp_flags
  import fpc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [1:0]  fmt_i,
  input  logic        zero_cmp_i,
  input  logic        nan_trap_all_i,
  input  logic [63:0] op_a_i,
  input  logic [63:0] op_b_i,
  input  logic        clr_inv_i,
  output logic [3:0]  nzcv_o,
  output logic [31:0] status_o,
  output logic        inv_sticky_o,
  output logic        bad_fmt_o
);
  localparam int STAT_W = 32;

  fmt_e            fmt;
  logic [OP_W-1:0] ops [NUM_OPS];
  fp_fields_t      flds [NUM_OPS];
  logic [3:0]      nzcv_d, nzcv_q;
  logic            inv_d, inv_q, bad_q, legal;

  assign fmt    = fmt_e'(fmt_i);
  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;
  assign legal  = valid_i && (fmt != FMT_BAD);

  for (genvar gi = 0; gi < NUM_OPS; gi++) begin : g_unp
    fpc_unpack u_unp (
      .fmt_i       (fmt),
      .force_zero_i((gi == 1) && zero_cmp_i),
      .op_i        (ops[gi]),
      .fld_o       (flds[gi])
    );
  end

  fpc_order u_order (
    .a_i           (flds[0]),
    .b_i           (flds[1]),
    .nan_trap_all_i(nan_trap_all_i),
    .nzcv_o        (nzcv_d),
    .inv_o         (inv_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nzcv_q <= '0;
      inv_q  <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      if (legal) nzcv_q <= nzcv_d;
      inv_q <= (inv_q & ~clr_inv_i) | (legal & inv_d);  // set wins over clear
      bad_q <= valid_i && (fmt == FMT_BAD);
    end
  end

  assign nzcv_o       = nzcv_q;
  assign status_o     = {nzcv_q, {(STAT_W-4){1'b0}}};
  assign inv_sticky_o = inv_q;
  assign bad_fmt_o    = bad_q;
endmodule

// File: rtl/fp_cmp_flags_chk.sv
module fp_cmp_flags_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [1:0]  fmt_i,
  input logic        zero_cmp_i,
  input logic        nan_trap_all_i,
  input logic [63:0] op_a_i,
  input logic [63:0] op_b_i,
  input logic        clr_inv_i,
  input logic [3:0]  nzcv_o,
  input logic [31:0] status_o,
  input logic        inv_sticky_o,
  input logic        bad_fmt_o
);
  assert_bad_fmt_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && fmt_i == 2'b00 |=> bad_fmt_o && $stable(nzcv_o));

  assert_bad_fmt_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && fmt_i == 2'b00) |=> !bad_fmt_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(nzcv_o));

  assert_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nzcv_o inside {4'b0000, 4'b1000, 4'b0110, 4'b0010, 4'b0011});

  assert_status_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o == {nzcv_o, 28'h0});

  assert_sticky_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_sticky_o && !clr_inv_i |=> inv_sticky_o);

  assert_sticky_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_inv_i && !valid_i |=> !inv_sticky_o);

  assert_self_eq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && fmt_i == 2'b10 && !zero_cmp_i &&
    ((op_a_i ^ op_b_i) & 64'hFFFF_FFFF) == 64'h0 &&
    (op_a_i & 64'h7F80_0000) != 64'h7F80_0000 |=> nzcv_o == 4'b0110);

  assert_zero_cmp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && fmt_i == 2'b11 && zero_cmp_i &&
    (op_a_i & 64'h7FFF_FFFF_FFFF_FFFF) == 64'h0 |=> nzcv_o == 4'b0110);

  assert_trap_any_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && fmt_i == 2'b11 && nan_trap_all_i &&
    (op_a_i & 64'h7FF0_0000_0000_0000) == 64'h7FF0_0000_0000_0000 &&
    (op_a_i & 64'h000F_FFFF_FFFF_FFFF) != 64'h0 |=> inv_sticky_o && nzcv_o == 4'b0011);
endmodule

bind fp_cmp_flags fp_cmp_flags_chk chk_i (.*);

// File: tb/fp_cmp_flags_tb_top.sv
`timescale 1ns/1ps
module fp_cmp_flags_tb_top;
  localparam real CLK_HALF = 4.0;
  localparam int  WD_CYC   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [1:0]  fmt = 2'b11;
  logic        zc = 1'b0;
  logic        trap_all = 1'b0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        clr = 1'b0;
  logic [3:0]  nzcv;
  logic [31:0] status;
  logic        inv;
  logic        bad;

  int checks = 0;
  int fails = 0;
  logic [3:0] exp_nzcv = 4'b0000;
  logic       exp_inv = 1'b0;

  always #(CLK_HALF) clk = ~clk;

  fp_cmp_flags dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .fmt_i(fmt),
    .zero_cmp_i(zc), .nan_trap_all_i(trap_all), .op_a_i(a), .op_b_i(b),
    .clr_inv_i(clr), .nzcv_o(nzcv), .status_o(status),
    .inv_sticky_o(inv), .bad_fmt_o(bad)
  );

  function automatic int ew_of(logic [1:0] f);
    return (f == 2'b01) ? 5 : (f == 2'b10) ? 8 : 11;
  endfunction
  function automatic int fw_of(logic [1:0] f);
    return (f == 2'b01) ? 10 : (f == 2'b10) ? 23 : 52;
  endfunction

  // returns {nzcv, invalid}
  function automatic logic [4:0] ref_cmp(logic [1:0] f, logic [63:0] x, logic [63:0] y,
                                         logic zero_b, logic any_nan);
    int ew = ew_of(f);
    int fw = fw_of(f);
    logic [63:0] emax = (64'd1 << ew) - 1;
    logic [63:0] fmask = (64'd1 << fw) - 1;
    logic [63:0] mmask = (64'd1 << (ew + fw)) - 1;
    logic [63:0] yy = zero_b ? 64'd0 : y;
    logic sx = x[ew+fw], sy = yy[ew+fw];
    logic [63:0] mx = x & mmask, my = yy & mmask;
    logic nx = ((mx >> fw) == emax) && ((mx & fmask) != 0);
    logic ny = ((my >> fw) == emax) && ((my & fmask) != 0);
    logic qx = nx && ((mx >> (fw - 1)) & 64'd1) != 0;
    logic qy = ny && ((my >> (fw - 1)) & 64'd1) != 0;
    logic [3:0] r;
    logic iv;
    if (nx || ny) r = 4'b0011;
    else if (mx == 0 && my == 0) r = 4'b0110;
    else if (sx != sy) r = sx ? 4'b1000 : 4'b0010;
    else if (mx == my) r = 4'b0110;
    else if ((mx < my) ^ sx) r = 4'b1000;
    else r = 4'b0010;
    iv = any_nan ? (nx || ny) : ((nx && !qx) || (ny && !qy));
    return {r, iv};
  endfunction

  // kind: 0 random, 1 zero, 2 inf, 3 qnan, 4 snan, 5 small finite
  function automatic logic [63:0] mk_op(logic [1:0] f, int kind, logic [63:0] rnd, logic sgn);
    int ew = ew_of(f);
    int fw = fw_of(f);
    logic [63:0] wmask = (64'd1 << (ew + fw + 1)) - 1;
    logic [63:0] fmask = (64'd1 << fw) - 1;
    logic [63:0] emax = (64'd1 << ew) - 1;
    logic [63:0] v;
    if (f == 2'b11) wmask = '1;
    case (kind)
      1: v = 64'd0;
      2: v = emax << fw;
      3: v = (emax << fw) | (64'd1 << (fw - 1)) | (rnd & (fmask >> 1));
      4: v = (emax << fw) | ((rnd & (fmask >> 1)) | 64'd1);
      5: v = ((64'd1 + (rnd & 64'h3)) << fw) | (rnd & 64'h7);
      default: v = rnd & ((64'd1 << (ew + fw)) - 1);
    endcase
    v = v | (64'(sgn) << (ew + fw));
    return (v & wmask) | (~wmask & {rnd[31:0], rnd[63:32]});
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic run_cmp(string req, logic [1:0] f, logic [63:0] x, logic [63:0] y,
                         logic zero_b, logic any_nan);
    logic [4:0] r;
    @(negedge clk);
    fmt = f; a = x; b = y; zc = zero_b; trap_all = any_nan; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    if (f != 2'b00) begin
      r = ref_cmp(f, x, y, zero_b, any_nan);
      exp_nzcv = r[4:1];
      exp_inv = exp_inv | r[0];
    end
    check(req, "nzcv", 32'(nzcv), 32'(exp_nzcv));
    check(req, "inv", 32'(inv), 32'(exp_inv));
    check("R2", "bad_fmt", 32'(bad), 32'(f == 2'b00));
    check("R9", "status", status, {exp_nzcv, 28'h0});
  endtask

  task automatic clear_inv();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    exp_inv = 1'b0;
    check("R8", "inv after clear", 32'(inv), 32'(0));
  endtask

  initial begin
    #(CLK_HALF * 2.0 * WD_CYC);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R11", "reset nzcv", 32'(nzcv), 32'(0));
    check("R11", "reset inv", 32'(inv), 32'(0));
    check("R11", "reset bad", 32'(bad), 32'(0));
    rst_n = 1'b1;

    // R3 ordering and signed zero / infinity corners
    run_cmp("R3", 2'b10, 64'h3F80_0000, 64'h4000_0000, 1'b0, 1'b0); // 1<2
    run_cmp("R3", 2'b10, 64'h4000_0000, 64'h3F80_0000, 1'b0, 1'b0); // 2>1
    run_cmp("R3", 2'b11, 64'h8000_0000_0000_0000, 64'h0, 1'b0, 1'b0); // -0 == +0
    run_cmp("R3", 2'b01, 64'hFC00, 64'h7C00, 1'b0, 1'b0); // -inf < +inf
    run_cmp("R3", 2'b01, 64'h7C00, 64'h7C00, 1'b0, 1'b0); // inf == inf
    run_cmp("R3", 2'b11, 64'hC000_0000_0000_0000, 64'hBFF0_0000_0000_0000, 1'b0, 1'b0); // -2<-1
    // R1 upper garbage ignored
    run_cmp("R1", 2'b01, 64'hDEAD_BEEF_1234_3C00, 64'h0123_4567_89AB_3C00, 1'b0, 1'b0);
    run_cmp("R1", 2'b10, 64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_BF80_0000, 1'b0, 1'b0);
    // R5 zero compare, op_b ignored
    run_cmp("R5", 2'b10, 64'hBF80_0000, 64'hC000_0000, 1'b1, 1'b0);
    run_cmp("R5", 2'b01, 64'h8000, 64'h7E00, 1'b1, 1'b1);
    check("R5", "inv untouched by ignored NaN", 32'(inv), 32'(0));
    // R4/R7 quiet NaN, no trap
    run_cmp("R7", 2'b10, 64'h7FC0_0000, 64'h3F80_0000, 1'b0, 1'b0);
    check("R4", "unordered", 32'(nzcv), 32'(4'b0011));
    check("R7", "qnan no trap", 32'(inv), 32'(0));
    // R7 signalling NaN sets sticky
    run_cmp("R7", 2'b11, 64'h0, 64'h7FF0_0000_0000_0001, 1'b0, 1'b0);
    check("R7", "snan trap", 32'(inv), 32'(1));
    // R2 illegal format holds flags
    run_cmp("R2", 2'b00, 64'h3F80_0000, 64'h7FC0_0000, 1'b0, 1'b1);
    clear_inv();
    // R6 quiet NaN with trap-all
    run_cmp("R6", 2'b01, 64'h7E00, 64'h0, 1'b0, 1'b1);
    check("R6", "qnan trap-all", 32'(inv), 32'(1));
    // R8 set wins over simultaneous clear
    @(negedge clk);
    fmt = 2'b10; a = 64'h7FA0_0000; b = '0; zc = 1'b0; trap_all = 1'b0;
    valid = 1'b1; clr = 1'b1;
    @(negedge clk);
    valid = 1'b0; clr = 1'b0;
    exp_nzcv = 4'b0011;
    check("R8", "set beats clear", 32'(inv), 32'(1));
    clear_inv();
    // R10 hold across idle cycles
    repeat (3) @(negedge clk);
    check("R10", "hold idle", 32'(nzcv), 32'(exp_nzcv));

    for (int i = 0; i < 600; i++) begin
      logic [1:0] f = 2'($urandom_range(1, 3));
      logic [63:0] ra = {$urandom, $urandom};
      logic [63:0] rb = {$urandom, $urandom};
      logic [63:0] x = mk_op(f, $urandom_range(0, 5), ra, ra[7]);
      logic [63:0] y = mk_op(f, $urandom_range(0, 5), rb, rb[9]);
      if ($urandom_range(0, 7) == 0) y = x;
      if ($urandom_range(0, 31) == 0) f = 2'b00;
      run_cmp("R3", f, x, y, ($urandom_range(0, 5) == 0), 1'($urandom));
      if ($urandom_range(0, 15) == 0) clear_inv();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule